// File: doc/BRIEF.md
# DIMM Command Target Address Generator

This block produces the read addresses that carry one SDRAM initialisation command to every populated row of a two-socket memory system. A start strobe captures a 3-bit command code, a CAS latency select and an 8-bit row population word. The population word holds a 4-bit code for each socket. Each code is decoded into the module's total size and the size of its first bank. A nonzero first-bank size marks a dual-sided module that has a second row.

The block then visits socket 0 and then socket 1. For each socket it offers up to two 32-bit addresses on a valid/ready handshake. The first row starts at the running memory total. The second row starts one bank higher. The mode-register-set command adds a low-order offset that depends on the socket and on the CAS latency. A one-cycle done pulse ends the sequence. The normal-operation command reaches no DRAM row, so it produces no address and only the done pulse.

Top module: `dimm_cmd_addr_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `addr_valid`, `busy` and `done` are low.
- R2: The code for socket 0 is `row_pop[3:0]` and the code for socket 1 is `row_pop[7:4]`. Socket 0 is visited first.
- R3: Codes 0x0 to 0xF give total sizes in MB of 0, 8, 0, 16, 16, 24, 32, 32, 48, 64, 64, 96, 128, 128, 192 and 256. Code 0x2 counts as empty, and an empty socket produces no address.
- R4: Codes 0x0 to 0xF give first-bank sizes in MB of 0, 0, 0, 8, 0, 16, 16, 0, 32, 32, 0, 64, 64, 0, 128 and 128. A second address is produced only when this size is nonzero.
- R5: The first address of a socket is (running start in MB) × 2^20 + command offset. It comes before the second address.
- R6: The second address of a socket is (running start + first-bank size) × 2^20 + command offset.
- R7: The running start is 0 for socket 0. After each socket it grows by that socket's total size.
- R8: For every command code other than mode register set (3'b110), the command offset is 0.
- R9: For mode register set, the offset is 0x1D0 for socket 0 and 0x650 for socket 1 when `cl_sel` is 1 (CL3). It is 0x150 for socket 0 and 0x1A0 for socket 1 when `cl_sel` is 0 (CL2).
- R10: For the normal-operation command (3'b000), no address is offered, `busy` stays low, and `done` is high in the cycle after the start strobe.
- R11: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr` does not change in the next cycle.
- R12: A start strobe that arrives while `busy` is high has no effect on the address sequence or on `done`.
- R13: For any other command, `busy` rises in the cycle after the start strobe. `done` is a single-cycle pulse in the cycle after the last row is handled, it coincides with `busy` falling, and it is never high together with `addr_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a walk when the block is idle |
| cmd | input | 3 | Command code, captured at start |
| cl_sel | input | 1 | 1 selects CL3 offsets, 0 selects CL2 offsets |
| row_pop | input | 8 | Row population word, one 4-bit code per socket |
| addr_valid | output | 1 | A target address is offered |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr | output | 32 | Target byte address |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a command |

## Verification
The handshake properties assume that the consumer may hold `addr_ready` low for any number of cycles, and that the inputs other than `start` matter only in the cycle the strobe is taken. The stimulus varies ready with several stall patterns: always ready, and periodic stalls of one or two cycles. It changes `row_pop` and `cmd` freely while a walk runs. Every start is a one-cycle pulse. The only start issued while `busy` is high is the deliberate one in the test for ignored strobes.

// File: rtl/dcag_pkg.sv
package dcag_pkg;

    localparam int SOCKETS  = 2;
    localparam int CODE_W   = 4;
    localparam int POP_W    = SOCKETS * CODE_W;
    localparam int SOCK_W   = (SOCKETS > 1) ? $clog2(SOCKETS) : 1;
    localparam int SIZE_W   = 9;
    localparam int SUM_W    = SIZE_W + $clog2(SOCKETS);
    localparam int OFF_W    = 12;
    localparam int CMD_W    = 3;

    localparam logic [CMD_W-1:0] CMD_NORMAL = 3'd0;
    localparam logic [CMD_W-1:0] CMD_MRS    = 3'd6;

    typedef struct packed {
        logic [SIZE_W-1:0] total_mb;
        logic [SIZE_W-1:0] bank0_mb;
    } row_geom_t;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic             cl3;
        logic [POP_W-1:0] pop;
    } walk_req_t;

    function automatic logic [SIZE_W-1:0] code_total(input logic [CODE_W-1:0] c);
        logic [SIZE_W-1:0] t;
        case (c)
            4'h1:          t = 9'd8;
            4'h3, 4'h4:    t = 9'd16;
            4'h5:          t = 9'd24;
            4'h6, 4'h7:    t = 9'd32;
            4'h8:          t = 9'd48;
            4'h9, 4'hA:    t = 9'd64;
            4'hB:          t = 9'd96;
            4'hC, 4'hD:    t = 9'd128;
            4'hE:          t = 9'd192;
            4'hF:          t = 9'd256;
            default:       t = 9'd0;
        endcase
        return t;
    endfunction

    function automatic logic [SIZE_W-1:0] code_bank0(input logic [CODE_W-1:0] c);
        logic [SIZE_W-1:0] b;
        case (c)
            4'h3:          b = 9'd8;
            4'h5, 4'h6:    b = 9'd16;
            4'h8, 4'h9:    b = 9'd32;
            4'hB, 4'hC:    b = 9'd64;
            4'hE, 4'hF:    b = 9'd128;
            default:       b = 9'd0;
        endcase
        return b;
    endfunction

    function automatic logic [OFF_W-1:0] mode_offset(input logic second_socket,
                                                     input logic cl3);
        logic [OFF_W-1:0] o;
        case ({second_socket, cl3})
            2'b01:   o = 12'h1D0;
            2'b11:   o = 12'h650;
            2'b00:   o = 12'h150;
            default: o = 12'h1A0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/dcag_decode.sv
module dcag_decode
    import dcag_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output row_geom_t         geom
);
    always_comb begin
        geom.total_mb = code_total(code);
        geom.bank0_mb = code_bank0(code);
    end
endmodule

// File: rtl/dcag_offset.sv
module dcag_offset
    import dcag_pkg::*;
(
    input  logic              is_mrs,
    input  logic              cl3,
    input  logic [SOCK_W-1:0] sock,
    output logic [OFF_W-1:0]  offset
);
    always_comb begin
        if (is_mrs)
            offset = mode_offset(sock[0], cl3);
        else
            offset = '0;
    end
endmodule

// File: rtl/dcag_seq.sv
module dcag_seq
    import dcag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  walk_req_t         req_in,
    input  row_geom_t         cur_geom,
    input  logic              ready,
    output walk_req_t         req_q,
    output logic [SOCK_W-1:0] sock,
    output logic              phase,
    output logic [SUM_W-1:0]  run_mb,
    output logic              busy,
    output logic              valid,
    output logic              done
);
    logic want;
    logic advance;
    logic last_row;

    always_comb begin
        want     = phase ? (cur_geom.bank0_mb != '0) : (cur_geom.total_mb != '0);
        valid    = busy && want;
        advance  = busy && (!want || ready);
        last_row = phase && (sock == SOCK_W'(SOCKETS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            sock   <= '0;
            phase  <= 1'b0;
            run_mb <= '0;
            req_q  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    req_q  <= req_in;
                    sock   <= '0;
                    phase  <= 1'b0;
                    run_mb <= '0;
                    if (req_in.cmd == CMD_NORMAL)
                        done <= 1'b1;
                    else
                        busy <= 1'b1;
                end
            end else if (advance) begin
                if (last_row) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else if (phase) begin
                    phase  <= 1'b0;
                    sock   <= sock + 1'b1;
                    run_mb <= run_mb + SUM_W'(cur_geom.total_mb);
                end else begin
                    phase <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dimm_cmd_addr_gen.sv
module dimm_cmd_addr_gen
    import dcag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MB_SHIFT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              cl_sel,
    input  logic [POP_W-1:0]  row_pop,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done
);
    walk_req_t         req_in;
    walk_req_t         req_q;
    logic [SOCK_W-1:0] sock;
    logic              phase;
    logic [SUM_W-1:0]  run_mb;
    row_geom_t         geom [SOCKETS];
    row_geom_t         cur_geom;
    logic [OFF_W-1:0]  offset;
    logic              mrs_q;
    logic [SUM_W-1:0]  base_mb;

    always_comb begin
        req_in.cmd = cmd;
        req_in.cl3 = cl_sel;
        req_in.pop = row_pop;
        mrs_q      = (req_q.cmd == CMD_MRS);
    end

    for (genvar s = 0; s < SOCKETS; s++) begin : g_dec
        dcag_decode u_dec (
            .code (req_q.pop[s*CODE_W +: CODE_W]),
            .geom (geom[s])
        );
    end

    assign cur_geom = geom[sock];

    dcag_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req_in   (req_in),
        .cur_geom (cur_geom),
        .ready    (addr_ready),
        .req_q    (req_q),
        .sock     (sock),
        .phase    (phase),
        .run_mb   (run_mb),
        .busy     (busy),
        .valid    (addr_valid),
        .done     (done)
    );

    dcag_offset u_off (
        .is_mrs (mrs_q),
        .cl3    (req_q.cl3),
        .sock   (sock),
        .offset (offset)
    );

    always_comb begin
        base_mb = phase ? (run_mb + SUM_W'(cur_geom.bank0_mb)) : run_mb;
        addr    = (ADDR_W'(base_mb) << MB_SHIFT) + ADDR_W'(offset);
    end
endmodule

// File: rtl/dcag_props.sv
module dcag_props #(
    parameter int ADDR_W   = 32,
    parameter int MB_SHIFT = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [2:0]        cmd,
    input logic              addr_valid,
    input logic              addr_ready,
    input logic [ADDR_W-1:0] addr,
    input logic              busy,
    input logic              done,
    input logic              mrs_q
);
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
        addr_valid && !addr_ready |=> addr_valid && $stable(addr)); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R13

    AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        done |-> !addr_valid); // R13

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !addr_valid); // R13

    AST_NORMAL_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
        start && !busy && cmd == 3'd0 |=> done && !busy); // R10

    AST_PLAIN_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        addr_valid && !mrs_q |-> addr[MB_SHIFT-1:0] == '0); // R8
endmodule

bind dimm_cmd_addr_gen dcag_props #(.ADDR_W(ADDR_W), .MB_SHIFT(MB_SHIFT)) u_props (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cmd        (cmd),
    .addr_valid (addr_valid),
    .addr_ready (addr_ready),
    .addr       (addr),
    .busy       (busy),
    .done       (done),
    .mrs_q      (mrs_q)
);

// File: tb/tb_dimm_cmd_addr_gen.sv
module tb_dimm_cmd_addr_gen;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]       rp;
        logic [2:0]       cmd;
        logic             cl3;
        logic [2:0]       n;
        logic [0:3][31:0] a;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 3'd1, 1'b1, 3'd0, {32'h0, 32'h0, 32'h0, 32'h0}},
        '{8'h01, 3'd1, 1'b1, 3'd1, {32'h0, 32'h0, 32'h0, 32'h0}},
        '{8'h3E, 3'd7, 1'b1, 3'd4, {32'h0000_0000, 32'h0800_0000, 32'h0C00_0000, 32'h0C80_0000}},
        '{8'h3E, 3'd6, 1'b1, 3'd4, {32'h0000_01D0, 32'h0800_01D0, 32'h0C00_0650, 32'h0C80_0650}},
        '{8'h5F, 3'd6, 1'b0, 3'd4, {32'h0000_0150, 32'h0800_0150, 32'h1000_01A0, 32'h1100_01A0}},
        '{8'h92, 3'd2, 1'b1, 3'd2, {32'h0000_0000, 32'h0200_0000, 32'h0, 32'h0}},
        '{8'h70, 3'd6, 1'b1, 3'd1, {32'h0000_0650, 32'h0, 32'h0, 32'h0}},
        '{8'hFF, 3'd7, 1'b0, 3'd4, {32'h0000_0000, 32'h0800_0000, 32'h1000_0000, 32'h1800_0000}},
        '{8'hFF, 3'd0, 1'b1, 3'd0, {32'h0, 32'h0, 32'h0, 32'h0}}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  cmd = '0;
    logic        cl_sel = 1'b0;
    logic [7:0]  row_pop = '0;
    logic        addr_valid;
    logic        addr_ready = 1'b0;
    logic [31:0] addr;
    logic        busy;
    logic        done;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] got [8];
    int          n_got;
    int          done_cyc;

    always #(CLK_PERIOD/2) clk = ~clk;

    dimm_cmd_addr_gen dut (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .cl_sel(cl_sel),
        .row_pop(row_pop), .addr_valid(addr_valid), .addr_ready(addr_ready),
        .addr(addr), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input vec_t v, input int stall, input bit poke);
        bit          pv;
        bit          pr;
        logic [31:0] pa;
        int          cyc;
        @(negedge clk);
        row_pop = v.rp; cmd = v.cmd; cl_sel = v.cl3; start = 1'b1;
        @(negedge clk);
        start = 1'b0; row_pop = 8'hA5; cmd = 3'd5; cl_sel = ~v.cl3;
        n_got = 0; cyc = 1; pv = 0; pr = 1; pa = '0; done_cyc = -1;
        if (v.cmd == 3'd0)
            check(!busy, "R10 busy stays low", 32'(busy), 32'd0);
        else
            check(busy, "R13 busy after start", 32'(busy), 32'd1);
        while (cyc < 60) begin
            if (pv && !pr)
                check(addr_valid && addr == pa, "R11 hold while stalled", addr, pa);
            if (done) begin
                check(!addr_valid, "R13 done without valid", 32'(addr_valid), 32'd0);
                done_cyc = cyc;
                break;
            end
            if (poke && cyc == 3) begin
                start = 1'b1; cmd = 3'd0; row_pop = 8'h00;
            end else begin
                start = 1'b0;
            end
            addr_ready = (stall == 0) ? 1'b1 : ((cyc % (stall + 1)) == 0);
            if (addr_valid && addr_ready) begin
                if (n_got < 8) got[n_got] = addr;
                n_got++;
            end
            pv = addr_valid; pr = addr_ready; pa = addr;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        addr_ready = 1'b0;
        check(done_cyc > 0, "R13 done reached", 32'(done_cyc), 32'd1);
        @(negedge clk);
        check(!done && !busy, "R13 done one cycle", {30'd0, done, busy}, 32'd0);
    endtask

    task automatic compare(input vec_t v, input string tag);
        check(n_got == int'(v.n), {tag, " address count"}, 32'(n_got), 32'(v.n));
        for (int k = 0; k < 4; k++) begin
            if (k < int'(v.n) && k < n_got)
                check(got[k] == v.a[k], {tag, " address value"}, got[k], v.a[k]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!addr_valid && !busy && !done, "R1 outputs in reset",
              {29'd0, addr_valid, busy, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!addr_valid && !busy && !done, "R1 outputs after release",
              {29'd0, addr_valid, busy, done}, 32'd0);

        // R2 R3 R4 R5 R6 R7 R8 R9 R10: vector table
        for (int i = 0; i < NV; i++) begin
            run(VECS[i], i % 3, 1'b0);
            if (VECS[i].cmd == 3'd0)
                check(done_cyc == 1, "R10 done the cycle after start", 32'(done_cyc), 32'd1);
            compare(VECS[i], "R2-R9 vector");
        end

        // R12: a start during a walk is ignored
        run(VECS[3], 2, 1'b1);
        compare(VECS[3], "R12 start while busy");

        // R1: reset in the middle of a walk
        @(negedge clk);
        row_pop = 8'hFF; cmd = 3'd7; start = 1'b1; addr_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!addr_valid && !busy && !done, "R1 reset mid walk",
              {29'd0, addr_valid, busy, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!addr_valid && !busy && !done, "R1 idle after mid reset",
              {29'd0, addr_valid, busy, done}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule